// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Fixed Off-Time Chopping

This block is the digital core of a single full-bridge brushed DC motor driver. Two direction inputs select one of four bridge commands. The block drives four gate-enable outputs, one high-side and one low-side for each half-bridge. A digital overcurrent comparator input ends each on-phase early. After a trip the bridge recirculates the motor current through both low-side switches for a fixed number of cycles, then resumes driving.

Every gate transition follows one rule. A switch may turn on only after its partner on the same leg has been off for a programmable dead time. This applies to command changes, to entering the off-time and to leaving it. The comparator is ignored for a programmable blanking window after every change on the gate outputs, so that switching transients cannot start a trip. A supervisor input forces all gates off at once and discards any chopping phase in progress. The three timing windows are parameters in clock cycles. Their defaults are derived from `CLK_HZ`, with blanking at 3 µs.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is applied and after it is released with both direction inputs low, all four gate outputs and `latch_reset` are low.
- R2: Command `{dir_a,dir_b}` = 2'b10 drives `gate_hs_a` and `gate_ls_b`. Command 2'b01 drives `gate_hs_b` and `gate_ls_a`. In the `{hs_a,ls_a,hs_b,ls_b}` vector these are 4'b1001 and 4'b0110.
- R3: Command 2'b11 drives both low-side gates and no high-side gate (4'b0101). An asserted `oc_trip` never starts chopping while this command is active.
- R4: Command 2'b00 turns all four gates off, and `oc_trip` has no effect.
- R5: On a command change, the next cycle keeps only the gates common to the present outputs and the new pattern. The new pattern appears after exactly `DEAD_CYC` cycles in that state. A further change during the wait restarts it from the gates then present. No gate rises unless its leg partner has been low for at least `DEAD_CYC` cycles.
- R6: While a diagonal command is driving and the comparator is not blanked, a high `oc_trip` sampled at a clock edge turns the active high-side gate off in the next cycle. In that same cycle `latch_reset` is high, for one cycle only.
- R7: `oc_trip` is ignored for `BLANK_CYC` cycles, starting with the cycle in which any gate output changes.
- R8: After a trip, only the low-side gate of the driven leg stays on for `DEAD_CYC` cycles. Then both low-side gates are on for `OFF_CYC` cycles. Then the recirculating low-side gate is off for `DEAD_CYC` cycles before the high-side gate returns, which starts a new blanking window. `oc_trip` is ignored during this sequence.
- R9: `drive_off` forces all four gates low in the same cycle. Once it falls, the gates stay low for `DEAD_CYC` cycles. The commanded drive pattern then returns, and any off-time that was in progress is abandoned.
- R10: The high-side and low-side gates of one leg are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_a | input | 1 | Direction input for leg A |
| dir_b | input | 1 | Direction input for leg B |
| oc_trip | input | 1 | Overcurrent comparator output, high when the peak current is reached |
| drive_off | input | 1 | Supervisor disable, forces all gates off |
| gate_hs_a | output | 1 | High-side gate enable, leg A |
| gate_ls_a | output | 1 | Low-side gate enable, leg A |
| gate_hs_b | output | 1 | High-side gate enable, leg B |
| gate_ls_b | output | 1 | Low-side gate enable, leg B |
| latch_reset | output | 1 | One-cycle pulse when a comparator trip ends the on-phase |

## Verification
The hardest situation to reach is a disable that arrives while the off-time is in progress. It must show that the chopping state is discarded, and not merely that it is masked until the off-time ends. To get there, the stimulus holds the comparator high from the command change onward, so the trip lands exactly on the first unblanked cycle. It releases the comparator during recirculation and then raises `drive_off` a few cycles into the double-low-side phase. The drive must return `DEAD_CYC` cycles after release, well before the natural end of the off-time. A second hard-to-reach case is a command that changes again while the dead-time wait is running. The stimulus reaches it by issuing a direction change two cycles after leaving brake.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Command word is {dir_a, dir_b}
  typedef enum logic [1:0] {
    CMD_COAST = 2'b00,
    CMD_REV   = 2'b01,
    CMD_FWD   = 2'b10,
    CMD_BRAKE = 2'b11
  } cmd_t;

  // Bit order [3:0] = hs_a, ls_a, hs_b, ls_b
  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_t;

  typedef enum logic [2:0] {
    PH_SWITCH,
    PH_RUN,
    PH_CHOP_DT,
    PH_CHOP_OFF,
    PH_RESUME_DT
  } phase_t;

  function automatic gate_t drive_of(cmd_t c);
    gate_t g;
    g = '0;
    unique case (c)
      CMD_FWD:   begin g.hs_a = 1'b1; g.ls_b = 1'b1; end
      CMD_REV:   begin g.hs_b = 1'b1; g.ls_a = 1'b1; end
      CMD_BRAKE: begin g.ls_a = 1'b1; g.ls_b = 1'b1; end
      default:   g = '0;
    endcase
    return g;
  endfunction

  // Recirculation pattern: low side of the driven path, optionally both low sides
  function automatic gate_t recirc_of(cmd_t c, logic both_low);
    gate_t g;
    g = '0;
    unique case (c)
      CMD_FWD: begin g.ls_b = 1'b1; g.ls_a = both_low; end
      CMD_REV: begin g.ls_a = 1'b1; g.ls_b = both_low; end
      default: g = '0;
    endcase
    return g;
  endfunction

  function automatic logic is_diag(cmd_t c);
    return (c == CMD_FWD) || (c == CMD_REV);
  endfunction

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  logic dir_a,
  input  logic dir_b,
  output cmd_t cmd
);

  always_comb begin
    unique case ({dir_a, dir_b})
      2'b10:   cmd = CMD_FWD;
      2'b01:   cmd = CMD_REV;
      2'b11:   cmd = CMD_BRAKE;
      default: cmd = CMD_COAST;
    endcase
  end

endmodule

// File: rtl/hb_timer.sv
module hb_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 25,
  parameter int OFF_CYC  = 3125
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_t  cmd,
  input  logic  drive_off,
  input  logic  oc_valid,
  output gate_t gates,
  output logic  trip_pulse,
  output logic  gates_change
);

  localparam int PMAX = (OFF_CYC > DEAD_CYC) ? OFF_CYC : DEAD_CYC;
  localparam int PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] DEAD_LD = PW'(DEAD_CYC - 1);
  localparam logic [PW-1:0] OFF_LD  = PW'(OFF_CYC - 1);

  phase_t        phase_q, phase_d;
  cmd_t          act_q, act_d;
  cmd_t          pend_q, pend_d;
  gate_t         mask_q, mask_d;
  gate_t         gates_q, gates_d;
  logic          trip_q, trip_d;
  logic          tmr_ld;
  logic [PW-1:0] tmr_val;
  logic          tmr_done;

  hb_timer #(.W(PW)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    act_d   = act_q;
    pend_d  = pend_q;
    mask_d  = mask_q;
    tmr_ld  = 1'b0;
    tmr_val = DEAD_LD;
    trip_d  = 1'b0;

    if (drive_off) begin
      phase_d = PH_SWITCH;
      mask_d  = '0;
      pend_d  = cmd;
      tmr_ld  = 1'b1;
    end else if (phase_q == PH_SWITCH) begin
      if (cmd != pend_q) begin
        pend_d = cmd;
        mask_d = gates_q & drive_of(cmd);
        tmr_ld = 1'b1;
      end else if (tmr_done) begin
        phase_d = PH_RUN;
        act_d   = pend_q;
      end
    end else if (cmd != act_q) begin
      phase_d = PH_SWITCH;
      pend_d  = cmd;
      mask_d  = gates_q & drive_of(cmd);
      tmr_ld  = 1'b1;
    end else begin
      unique case (phase_q)
        PH_RUN: begin
          if (oc_valid && is_diag(act_q)) begin
            phase_d = PH_CHOP_DT;
            tmr_ld  = 1'b1;
            trip_d  = 1'b1;
          end
        end
        PH_CHOP_DT: begin
          if (tmr_done) begin
            phase_d = PH_CHOP_OFF;
            tmr_ld  = 1'b1;
            tmr_val = OFF_LD;
          end
        end
        PH_CHOP_OFF: begin
          if (tmr_done) begin
            phase_d = PH_RESUME_DT;
            tmr_ld  = 1'b1;
          end
        end
        PH_RESUME_DT: begin
          if (tmr_done) phase_d = PH_RUN;
        end
        default: phase_d = PH_SWITCH;
      endcase
    end
  end

  // Gate pattern for the next phase
  always_comb begin
    unique case (phase_d)
      PH_RUN:       gates_d = drive_of(act_d);
      PH_CHOP_DT:   gates_d = recirc_of(act_d, 1'b0);
      PH_CHOP_OFF:  gates_d = recirc_of(act_d, 1'b1);
      PH_RESUME_DT: gates_d = recirc_of(act_d, 1'b0);
      default:      gates_d = mask_d;
    endcase
  end

  assign gates_change = (gates_d != gates_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SWITCH;
      act_q   <= CMD_COAST;
      pend_q  <= CMD_COAST;
      mask_q  <= '0;
      gates_q <= '0;
      trip_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      mask_q  <= mask_d;
      gates_q <= gates_d;
      trip_q  <= trip_d;
    end
  end

  assign gates      = gates_q;
  assign trip_pulse = trip_q;

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int BLANK_CYC = (CLK_HZ / 1_000_000) * 3,
  parameter int DEAD_CYC  = CLK_HZ / 5_000_000,
  parameter int OFF_CYC   = CLK_HZ / 40_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic oc_trip,
  input  logic drive_off,
  output logic gate_hs_a,
  output logic gate_ls_a,
  output logic gate_hs_b,
  output logic gate_ls_b,
  output logic latch_reset
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYC);

  logic       rst_s1_q, rst_s2_q;
  cmd_t       cmd;
  gate_t      gates;
  logic       gates_change;
  logic       blank_done;
  logic       oc_valid;
  logic [3:0] gate_vec;
  logic [3:0] gate_out;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  hb_cmd_decode u_decode (
    .dir_a (dir_a),
    .dir_b (dir_b),
    .cmd   (cmd)
  );

  hb_timer #(.W(BW)) u_blank_tmr (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .load     (gates_change),
    .load_val (BLANK_LD),
    .done     (blank_done)
  );

  assign oc_valid = oc_trip && blank_done;

  hb_phase_fsm #(
    .DEAD_CYC (DEAD_CYC),
    .OFF_CYC  (OFF_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_s2_q),
    .cmd          (cmd),
    .drive_off    (drive_off),
    .oc_valid     (oc_valid),
    .gates        (gates),
    .trip_pulse   (latch_reset),
    .gates_change (gates_change)
  );

  assign gate_vec = gates;

  for (genvar k = 0; k < 4; k++) begin : g_force_off
    assign gate_out[k] = gate_vec[k] && !drive_off;
  end

  assign gate_hs_a = gate_out[3];
  assign gate_ls_a = gate_out[2];
  assign gate_hs_b = gate_out[1];
  assign gate_ls_b = gate_out[0];

endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk #(
  parameter int DEAD_CYC = 25
) (
  input logic clk,
  input logic rst_n,
  input logic dir_a,
  input logic dir_b,
  input logic drive_off,
  input logic gate_hs_a,
  input logic gate_ls_a,
  input logic gate_hs_b,
  input logic gate_ls_b,
  input logic latch_reset
);

  localparam int CW = $clog2(DEAD_CYC + 1);

  logic [3:0]    g;
  logic [CW-1:0] low_cnt [4];

  assign g = {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b};

  for (genvar i = 0; i < 4; i++) begin : g_low_track
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         low_cnt[i] <= CW'(DEAD_CYC);
      else if (g[i])                      low_cnt[i] <= '0;
      else if (low_cnt[i] < CW'(DEAD_CYC)) low_cnt[i] <= low_cnt[i] + CW'(1);
    end

    // R5: a gate rises only after its leg partner was low for the dead time
    assert_dead_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g[i]) |-> (low_cnt[i ^ 1] >= CW'(DEAD_CYC)));
  end

  assert_no_shoot_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs_a && gate_ls_a));

  assert_no_shoot_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs_b && gate_ls_b));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_reset |=> !latch_reset);

  assert_trip_hs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_reset |-> (!gate_hs_a && !gate_hs_b));

  assert_trip_diag_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_reset |-> $past(dir_a ^ dir_b));

  assert_release_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_off) |-> (g == 4'b0000));

endmodule

bind hbridge_ctrl hbridge_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir_a       (dir_a),
  .dir_b       (dir_b),
  .drive_off   (drive_off),
  .gate_hs_a   (gate_hs_a),
  .gate_ls_a   (gate_ls_a),
  .gate_hs_b   (gate_hs_b),
  .gate_ls_b   (gate_ls_b),
  .latch_reset (latch_reset)
);

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;

  localparam int D = 4;
  localparam int B = 12;
  localparam int O = 20;

  typedef struct {
    int         at;
    logic [3:0] g;
    logic       lr;
    string      req;
  } exp_t;

  logic clk, rst_n, dir_a, dir_b, oc_trip, drive_off;
  logic gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b, latch_reset;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;
  bit   overlap_seen = 0;
  exp_t sb[$];
  exp_t mon_e;

  hbridge_ctrl #(
    .BLANK_CYC (B),
    .DEAD_CYC  (D),
    .OFF_CYC   (O)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_a       (dir_a),
    .dir_b       (dir_b),
    .oc_trip     (oc_trip),
    .drive_off   (drive_off),
    .gate_hs_a   (gate_hs_a),
    .gate_ls_a   (gate_ls_a),
    .gate_hs_b   (gate_hs_b),
    .gate_ls_b   (gate_ls_b),
    .latch_reset (latch_reset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items when their cycle comes up
  always @(negedge clk) begin
    if ((gate_hs_a && gate_ls_a) || (gate_hs_b && gate_ls_b)) overlap_seen = 1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      mon_e = sb.pop_front();
      n_chk++;
      if (mon_e.at < cyc) begin
        n_err++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", mon_e.req, mon_e.at, cyc);
      end else if ({gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b} !== mon_e.g ||
                   latch_reset !== mon_e.lr) begin
        n_err++;
        $display("FAIL %s at cycle %0d: gates=%b latch_reset=%b expected gates=%b latch_reset=%b",
                 mon_e.req, cyc, {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b}, latch_reset,
                 mon_e.g, mon_e.lr);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_to(int x);
    while (cyc < x) tick();
  endtask

  task automatic push(int at, logic [3:0] g, logic lr, string req);
    exp_t e;
    e.at = at; e.g = g; e.lr = lr; e.req = req;
    sb.push_back(e);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n, t, r, x, t2, c, y, z, w, v, u;
    rst_n = 1'b0; dir_a = 1'b0; dir_b = 1'b0; oc_trip = 1'b0; drive_off = 1'b0;
    repeat (3) tick();
    push(cyc, 4'b0000, 1'b0, "R1");
    tick();
    rst_n = 1'b1;
    repeat (20) tick();
    push(cyc, 4'b0000, 1'b0, "R1");
    tick();

    // R2/R5/R6/R7/R8: forward with the comparator held high from the start
    n = cyc; dir_a = 1'b1; dir_b = 1'b0; oc_trip = 1'b1;
    push(n + 1, 4'b0000, 0, "R5");
    push(n + D, 4'b0000, 0, "R5");
    push(n + D + 1, 4'b1001, 0, "R2");
    push(n + D + 1 + B, 4'b1001, 0, "R7");
    t = n + D + B + 2;
    push(t, 4'b0001, 1, "R6");
    push(t + 1, 4'b0001, 0, "R6");
    push(t + D - 1, 4'b0001, 0, "R8");
    push(t + D, 4'b0101, 0, "R8");
    push(t + D + O - 1, 4'b0101, 0, "R8");
    push(t + D + O, 4'b0001, 0, "R8");
    push(t + 2*D + O - 1, 4'b0001, 0, "R8");
    r = t + 2*D + O;
    push(r, 4'b1001, 0, "R8");
    wait_to(t + D + 2); oc_trip = 1'b0;

    // R7: comparator pulse inside the new blanking window is ignored
    wait_to(r + 2); oc_trip = 1'b1;
    wait_to(r + 5); oc_trip = 1'b0;
    push(r + 6, 4'b1001, 0, "R7");
    push(r + B + 3, 4'b1001, 0, "R7");

    // R6: single-cycle comparator pulse after blanking
    x = r + B + 5;
    wait_to(x); oc_trip = 1'b1;
    push(x + 1, 4'b0001, 1, "R6");
    tick(); oc_trip = 1'b0;
    t2 = x + 1;

    // R9: disable during the off-time discards it
    c = t2 + D + 2;
    wait_to(c); drive_off = 1'b1;
    push(c, 4'b0000, 0, "R9");
    push(c + 2, 4'b0000, 0, "R9");
    wait_to(c + 3); drive_off = 1'b0;
    push(c + 3 + D - 1, 4'b0000, 0, "R9");
    push(c + 3 + D, 4'b1001, 0, "R9");

    // R2/R5: reverse
    y = c + 3 + D + B + 5;
    wait_to(y); dir_a = 1'b0; dir_b = 1'b1;
    push(y + 1, 4'b0000, 0, "R5");
    push(y + D, 4'b0000, 0, "R5");
    push(y + D + 1, 4'b0110, 0, "R2");

    // R8: reverse chopping sequence
    z = y + D + 1 + B + 2;
    wait_to(z); oc_trip = 1'b1;
    push(z + 1, 4'b0100, 1, "R6");
    tick(); oc_trip = 1'b0;
    push(z + D, 4'b0100, 0, "R8");
    push(z + 1 + D, 4'b0101, 0, "R8");
    push(z + D + O, 4'b0101, 0, "R8");
    push(z + 1 + D + O, 4'b0100, 0, "R8");
    push(z + 1 + 2*D + O, 4'b0110, 0, "R8");

    // R3/R5: brake with the comparator high
    w = z + 1 + 2*D + O + 3;
    wait_to(w); dir_a = 1'b1; dir_b = 1'b1; oc_trip = 1'b1;
    push(w + 1, 4'b0100, 0, "R5");
    push(w + D, 4'b0100, 0, "R5");
    push(w + D + 1, 4'b0101, 0, "R3");
    push(w + D + B + 11, 4'b0101, 0, "R3");
    wait_to(w + D + B + 12); oc_trip = 1'b0;

    // R5: second change during the dead-time wait restarts it
    v = w + D + B + 14;
    wait_to(v); dir_a = 1'b1; dir_b = 1'b0;
    push(v + 1, 4'b0001, 0, "R5");
    wait_to(v + 2); dir_a = 1'b0; dir_b = 1'b1;
    push(v + 2, 4'b0001, 0, "R5");
    push(v + 3, 4'b0000, 0, "R5");
    push(v + 2 + D, 4'b0000, 0, "R5");
    push(v + 3 + D, 4'b0110, 0, "R5");

    // R4: coast, comparator has no effect
    u = v + 3 + D + B;
    wait_to(u); dir_a = 1'b0; dir_b = 1'b0; oc_trip = 1'b1;
    push(u + 1, 4'b0000, 0, "R4");
    push(u + D + 1, 4'b0000, 0, "R4");
    push(u + D + B + 5, 4'b0000, 0, "R4");
    wait_to(u + D + B + 6); oc_trip = 1'b0;

    repeat (5) tick();
    n_chk++;
    if (sb.size() != 0) begin
      n_err++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    n_chk++;
    if (overlap_seen) begin
      n_err++;
      $display("FAIL R10: leg overlap seen=1 expected=0");
    end
    done = 1;
    summary();
    $finish;
  end

endmodule